// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block keeps a 32-bit count of elapsed seconds, advanced by a one-cycle pulse arriving once per second, and compares that count against a programmable 32-bit alarm value. Software reaches it through a small byte-wide register bus with a 4-bit offset, a write strobe, a read strobe and 8-bit data in each direction. When the count reaches the alarm value while the alarm is enabled, a sticky status bit is set and an interrupt line is driven high until software clears it.

A new time is written byte by byte. Offset 0x2 is the low byte of the load value and also the commit point. Software first writes 0x00 there, then the upper three bytes at offsets 0x3 to 0x5, and last the real low byte at 0x2. That final write moves the whole 32-bit value into the counter in one cycle. The live count is read at offsets 0x6 to 0x9 with no snapshot, so a reader that sees the low byte go down between two reads must read again.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the count, the alarm value, the load shadow, both control bits and the alarm status are 0, and `irq` is low.
- R2: Control register at offset 0x0: bit 7 enables counting. While bit 7 is 1, each cycle with `tick` high adds 1 to the count. While bit 7 is 0, the count keeps its value.
- R3: A write to offset 0x3, 0x4 or 0x5 stores count bits 15:8, 23:16 or 31:24 into a shadow only, and the count does not change. A write to offset 0x2 loads {shadow bits 31:8, write data} into the count. If `tick` is high in the same cycle, the load wins and the count equals the loaded value.
- R4: The count wraps from 0xFFFFFFFF to 0x00000000 on the next counted tick.
- R5: Reads are registered. With `rd_en` high at a clock edge, `rdata` shows the addressed register from that edge on and holds it while `rd_en` is low. Offsets 0x6 to 0x9 return live count bits 7:0, 15:8, 23:16 and 31:24.
- R6: Offsets 0xA to 0xD hold alarm bits 7:0, 15:8, 23:16 and 31:24 and read back as written. Control bit 1 enables the alarm. On the first cycle the count equals the alarm value with the enable set, the status bit (bit 0 at offset 0x1) is set one clock later. It stays set until cleared.
- R7: `irq` equals the status bit AND control bit 1. Clearing control bit 1 forces `irq` low without losing the status bit.
- R8: Writing a value with bit 0 set to offset 0x1 clears the status bit. A write with bit 0 clear has no effect. If a new match sets the status in the same cycle as a clear, the set wins.
- R9: Reading offset 0x0 returns the two control bits in positions 7 and 1, with all other bits 0. Reading offsets 0x3 to 0x5 returns the shadow bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Alarm interrupt, level high |

## Verification
Two pairs of events can collide in one cycle: a load commit and a counted tick, and a status clear and a fresh alarm match. The bench drives `tick` together with the commit write to offset 0x2 and expects exactly the loaded value. It also lines up a clear write with the cycle in which the status would be set, and expects the status to remain 1. Constrained-random loads and tick bursts check the little-endian read-back of the live count.

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm #(
  parameter int CW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);
  localparam int NB = CW / 8;
  localparam logic [AW-1:0] A_CTRL = 'h0, A_STAT = 'h1, A_LOAD = 'h2,
                            A_READ = 'h6, A_ALRM = 'hA;

  logic [CW-1:0] count_q, shadow_q, alarm_q;
  logic run_q, alen_q, stat_q, hit_q;
  logic [7:0] rd_mux;

  wire load_w  = wr_en && addr == A_LOAD;
  wire clr_w   = wr_en && addr == A_STAT && wdata[0];
  wire hit     = alen_q && (count_q == alarm_q);
  wire hit_new = hit && !hit_q;

  assign irq = stat_q & alen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      shadow_q <= '0;
      alarm_q <= '0;
      run_q <= 1'b0;
      alen_q <= 1'b0;
      stat_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (hit_new) stat_q <= 1'b1;
      else if (clr_w) stat_q <= 1'b0;
      if (load_w) count_q <= {shadow_q[CW-1:8], wdata};
      else if (run_q && tick) count_q <= count_q + 1'b1;
      if (wr_en) begin
        if (addr == A_CTRL) begin
          run_q <= wdata[7];
          alen_q <= wdata[1];
        end
        for (int i = 1; i < NB; i++)
          if (addr == A_LOAD + AW'(i)) shadow_q[8*i +: 8] <= wdata;
        for (int i = 0; i < NB; i++)
          if (addr == A_ALRM + AW'(i)) alarm_q[8*i +: 8] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL) rd_mux = {run_q, 5'b0, alen_q, 1'b0};
    if (addr == A_STAT) rd_mux = {7'b0, stat_q};
    for (int i = 1; i < NB; i++)
      if (addr == A_LOAD + AW'(i)) rd_mux = shadow_q[8*i +: 8];
    for (int i = 0; i < NB; i++) begin
      if (addr == A_READ + AW'(i)) rd_mux = count_q[8*i +: 8];
      if (addr == A_ALRM + AW'(i)) rd_mux = alarm_q[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_w) |=> (count_q == $past(count_q)));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !load_w) |=> (count_q == $past(count_q) + 1'b1));
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> (count_q[7:0] == $past(wdata)));
  a_r3_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_LOAD && !(run_q && tick)) |=> $stable(count_q));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_w) |=> stat_q);
  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !alen_q |-> !irq);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && !hit_new) |=> !stat_q);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_new |=> stat_q);
endmodule

// File: tb/rtc_sec_alarm_tb.sv
module rtc_sec_alarm_tb;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] exp_count;
  logic [7:0] rv;

  rtc_sec_alarm u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  function automatic logic [31:0] bump(logic [31:0] v, int n);
    return v + 32'(n);
  endfunction

  task automatic load(logic [31:0] v);
    wr(4'h2, 8'h00); wr(4'h3, v[15:8]); wr(4'h4, v[23:16]); wr(4'h5, v[31:24]);
    wr(4'h2, v[7:0]);
  endtask

  task automatic rd_count(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin rd(4'(6 + i), b); v[8*i +: 8] = b; end
  endtask

  task automatic set_alarm(logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(4'(10 + i), v[8*i +: 8]);
  endtask

  initial begin
    logic [31:0] got;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    rd_count(got); chk("R1 count", got, 0);
    rd(4'h0, rv); chk("R1 ctrl", {24'b0, rv}, 0);
    rd(4'h1, rv); chk("R1 status", {24'b0, rv}, 0);
    rst_n = 1;
    rd_count(got); chk("R1 count after release", got, 0);
    rd(4'hA, rv); chk("R1 alarm", {24'b0, rv}, 0);

    // R2 hold while disabled
    load(32'h0000_1234);
    repeat (3) pulse();
    rd_count(got); chk("R2 hold", got, 32'h0000_1234);
    // R9 control readback
    wr(4'h0, 8'hFF);
    rd(4'h0, rv); chk("R9 ctrl bits", {24'b0, rv}, 32'h82);
    wr(4'h0, 8'h80);
    rd(4'h0, rv); chk("R9 ctrl run", {24'b0, rv}, 32'h80);

    // R2/R5 random loads and tick bursts
    for (int t = 0; t < 20; t++) begin
      int n;
      exp_count = $urandom;
      n = $urandom_range(0, 6);
      load(exp_count);
      for (int k = 0; k < n; k++) pulse();
      rd_count(got); chk("R2 R5 random count", got, bump(exp_count, n));
    end

    // R3 shadow-only writes do not touch the count
    load(32'hA5A5_0010);
    wr(4'h3, 8'h11); wr(4'h4, 8'h22); wr(4'h5, 8'h33);
    rd_count(got); chk("R3 shadow only", got, 32'hA5A5_0010);
    rd(4'h4, rv); chk("R9 shadow readback", {24'b0, rv}, 32'h22);
    wr(4'h2, 8'h44);
    rd_count(got); chk("R3 commit", got, 32'h3322_1144);
    // R3 load wins over same-cycle tick
    @(negedge clk); wr_en = 1; addr = 4'h2; wdata = 8'h50; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
    rd_count(got); chk("R3 load beats tick", got, 32'h3322_1150);

    // R4 wrap
    load(32'hFFFF_FFFF);
    pulse();
    rd_count(got); chk("R4 wrap", got, 0);

    // R5 registered read holds while rd_en low
    rd(4'h6, rv);
    pulse();
    chk("R5 hold rdata", {24'b0, rdata}, 0);
    rd(4'h6, rv); chk("R5 live byte", {24'b0, rv}, 1);

    // R6 alarm match
    set_alarm(32'h0102_0304);
    rd(4'hD, rv); chk("R6 alarm readback", {24'b0, rv}, 32'h01);
    load(32'h0102_0303);
    wr(4'h0, 8'h82);
    chk("R6 no irq before match", {31'b0, irq}, 0);
    pulse();
    @(negedge clk);
    chk("R6 irq after match", {31'b0, irq}, 1);
    rd(4'h1, rv); chk("R6 status", {24'b0, rv}, 1);
    pulse();
    chk("R6 sticky", {31'b0, irq}, 1);

    // R8 write with bit0 clear has no effect
    wr(4'h1, 8'hFE);
    chk("R8 no clear", {31'b0, irq}, 1);
    // R7 mask
    wr(4'h0, 8'h80);
    chk("R7 masked", {31'b0, irq}, 0);
    rd(4'h1, rv); chk("R7 status kept", {24'b0, rv}, 1);
    wr(4'h0, 8'h82);
    chk("R7 unmasked", {31'b0, irq}, 1);
    // R8 clear
    wr(4'h1, 8'h01);
    chk("R8 cleared", {31'b0, irq}, 0);

    // R8 set wins over clear in the same cycle
    wr(4'h0, 8'h00);
    set_alarm(32'h0000_0200);
    load(32'h0000_01FF);
    wr(4'h0, 8'h82);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; wr_en = 1; addr = 4'h1; wdata = 8'h01;
    @(negedge clk); wr_en = 0;
    chk("R8 set beats clear", {31'b0, irq}, 1);
    wr(4'h1, 8'h01);
    chk("R8 final clear", {31'b0, irq}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule